// File: doc/BRIEF.md
# Dual-Port RAM Access Controller with Byte Lanes and Contention Flag

This block is a two-sided synchronous RAM with a controller in front of each side. Each side has a select, a read/write strobe, an output-drive enable and one active-low enable per byte lane. From these the controller works out which byte lanes are written and which lanes drive the read bus. The read bus is modelled as a data vector plus one drive-enable bit per lane. A cleared drive-enable bit stands for a lane held at high impedance.

The two sides share a contention flag, active low. When the role input is high, the block is the master. It compares the two addresses in each cycle and pulls the flag low towards the right side whenever both sides select the same word. Ties always go to the left side. A side that sees its flag low has its write dropped for that cycle, while reads still go ahead. When the role input is low, the block is a slave. It stops driving its flag outputs and instead takes the flags from an external master on its flag inputs.

Top module: `dpr_ctrl_top`

## Requirements
- R1: While a side's select is high, that side writes no byte, and in the next cycle its drive-enable vector is all zero.
- R2: For a write (select low, rw low), lane i (bits 8i+7:8i) is written only when be_n[i] is low. be_n[1] is the upper lane (bits 15:8) and be_n[0] is the lower lane (bits 7:0).
- R3: For a read (select low, rw high, oe_n low), in the next cycle rdata holds the addressed word and drv_en equals the bitwise inverse of the be_n that was presented.
- R4: For a read with oe_n high, drv_en is all zero in the next cycle.
- R5: In master mode, when both sides are selected at the same address, r_busy_out_n is low in that same cycle and l_busy_out_n stays high. In every other case both flags are high.
- R6: A write on a side whose effective flag is low leaves the memory unchanged.
- R7: In slave mode, both busy_out_n outputs are high and busy_drv is low. A low busy_in_n on a side drops that side's write.
- R8: Both sides may read the same word in the same cycle, and both receive it, even while the flag to the right side is low.
- R9: busy_drv follows the role input: it is high in master mode.
- R10: A read in the same cycle as a write to that word from the other side returns the old contents.
- R11: After reset, rdata is zero and drv_en is zero on both sides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| master_sel | input | 1 | Role input: 1 master (drives flags), 0 slave (honours flags) |
| l_cs_n | input | 1 | Left select, active low |
| l_rw | input | 1 | Left: 1 read, 0 write |
| l_oe_n | input | 1 | Left output-drive enable, active low |
| l_be_n | input | LANES | Left byte-lane enables, active low |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_busy_in_n | input | 1 | Left flag from external master (slave mode) |
| l_rdata | output | DATA_W | Left read data |
| l_drv_en | output | LANES | Left per-lane bus drive enable |
| l_busy_out_n | output | 1 | Left contention flag output |
| r_cs_n | input | 1 | Right select, active low |
| r_rw | input | 1 | Right: 1 read, 0 write |
| r_oe_n | input | 1 | Right output-drive enable, active low |
| r_be_n | input | LANES | Right byte-lane enables, active low |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_busy_in_n | input | 1 | Right flag from external master (slave mode) |
| r_rdata | output | DATA_W | Right read data |
| r_drv_en | output | LANES | Right per-lane bus drive enable |
| r_busy_out_n | output | 1 | Right contention flag output |
| busy_drv | output | 1 | High when the flag outputs are driven (master mode) |

## Verification
Writes are tried with all three lane patterns: both lanes, lower lane only and upper lane only. Each is followed by a full read, which shows whether the lane masks are swapped or ignored. Reads are tried with a single-lane mask and with the output drive disabled. These separate the lane mask on the drive from the drive gating. Pairs of accesses from the two sides are then tried: same-address writes, different-address writes, same-address reads and a read against a write. These show whether the flag is raised only on a true match, whether it lands on the right side, and whether the read sees the old or the new word. Slave-mode runs with the external flag held low show that the role input really switches the flag source.

// File: rtl/dpr_ctrl_pkg.sv
package dpr_ctrl_pkg;
   localparam int unsigned LANE_W = 8;
   typedef enum logic {ROLE_SLAVE = 1'b0, ROLE_MASTER = 1'b1} role_e;
endpackage

// File: rtl/dpr_port_decode.sv
module dpr_port_decode #(
   parameter int unsigned LANES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             rw,
   input  logic             oe_n,
   input  logic [LANES-1:0] be_n,
   input  logic             hold,
   output logic [LANES-1:0] wr_lane,
   output logic             rd_en,
   output logic [LANES-1:0] drv_en
);
   logic             sel;
   logic [LANES-1:0] drv_d;

   assign sel   = ~cs_n;
   assign rd_en = sel & rw;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign wr_lane[i] = sel & ~rw & ~hold & ~be_n[i];
      assign drv_d[i]   = sel & rw & ~oe_n & ~be_n[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) drv_en <= '0;
      else        drv_en <= drv_d;
   end
endmodule

// File: rtl/dpr_busy_arb.sv
module dpr_busy_arb #(
   parameter int unsigned ADDR_W = 10
) (
   input  logic              master_sel,
   input  logic              l_cs_n,
   input  logic              r_cs_n,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic              l_busy_in_n,
   input  logic              r_busy_in_n,
   output logic              l_busy_out_n,
   output logic              r_busy_out_n,
   output logic              busy_drv,
   output logic              l_hold,
   output logic              r_hold
);
   import dpr_ctrl_pkg::*;
   role_e role;
   logic  match;

   assign role  = role_e'(master_sel);
   assign match = ~l_cs_n & ~r_cs_n & (l_addr == r_addr);

   always_comb begin
      if (role == ROLE_MASTER) begin
         l_busy_out_n = 1'b1;
         r_busy_out_n = ~match;
         busy_drv     = 1'b1;
         l_hold       = 1'b0;
         r_hold       = match;
      end else begin
         l_busy_out_n = 1'b1;
         r_busy_out_n = 1'b1;
         busy_drv     = 1'b0;
         l_hold       = ~l_busy_in_n;
         r_hold       = ~r_busy_in_n;
      end
   end
endmodule

// File: rtl/dpr_mem_core.sv
module dpr_mem_core #(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned LANES  = 2,
   localparam int unsigned DATA_W = LANES * dpr_ctrl_pkg::LANE_W,
   localparam int unsigned DEPTH  = 2 ** ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   input  logic [LANES-1:0]  l_wr,
   input  logic              l_rd,
   output logic [DATA_W-1:0] l_rdata,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   input  logic [LANES-1:0]  r_wr,
   input  logic              r_rd,
   output logic [DATA_W-1:0] r_rdata
);
   localparam int unsigned LW = dpr_ctrl_pkg::LANE_W;
   logic [DATA_W-1:0] mem [DEPTH];

   // right first, left last: left wins a same-word write when nothing holds either side
   always_ff @(posedge clk) begin
      for (int i = 0; i < int'(LANES); i++) begin
         if (r_wr[i]) mem[r_addr][i*LW +: LW] <= r_wdata[i*LW +: LW];
      end
      for (int i = 0; i < int'(LANES); i++) begin
         if (l_wr[i]) mem[l_addr][i*LW +: LW] <= l_wdata[i*LW +: LW];
      end
   end

   // reads sample the array before this edge's writes land
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         l_rdata <= '0;
         r_rdata <= '0;
      end else begin
         if (l_rd) l_rdata <= mem[l_addr];
         if (r_rd) r_rdata <= mem[r_addr];
      end
   end
endmodule

// File: rtl/dpr_ctrl_top.sv
module dpr_ctrl_top #(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned LANES  = 2,
   localparam int unsigned DATA_W = LANES * dpr_ctrl_pkg::LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              master_sel,
   input  logic              l_cs_n,
   input  logic              l_rw,
   input  logic              l_oe_n,
   input  logic [LANES-1:0]  l_be_n,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   input  logic              l_busy_in_n,
   output logic [DATA_W-1:0] l_rdata,
   output logic [LANES-1:0]  l_drv_en,
   output logic              l_busy_out_n,
   input  logic              r_cs_n,
   input  logic              r_rw,
   input  logic              r_oe_n,
   input  logic [LANES-1:0]  r_be_n,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   input  logic              r_busy_in_n,
   output logic [DATA_W-1:0] r_rdata,
   output logic [LANES-1:0]  r_drv_en,
   output logic              r_busy_out_n,
   output logic              busy_drv
);
   if (ADDR_W < 1 || ADDR_W > 14) begin : g_bad_addr
      $error("dpr_ctrl_top: ADDR_W must be 1..14");
   end
   if (LANES < 1 || LANES > 4) begin : g_bad_lanes
      $error("dpr_ctrl_top: LANES must be 1..4");
   end

   logic             l_hold, r_hold, l_rd, r_rd;
   logic [LANES-1:0] l_wr, r_wr;

   dpr_busy_arb #(.ADDR_W(ADDR_W)) u_arb (
      .master_sel  (master_sel),
      .l_cs_n      (l_cs_n),
      .r_cs_n      (r_cs_n),
      .l_addr      (l_addr),
      .r_addr      (r_addr),
      .l_busy_in_n (l_busy_in_n),
      .r_busy_in_n (r_busy_in_n),
      .l_busy_out_n(l_busy_out_n),
      .r_busy_out_n(r_busy_out_n),
      .busy_drv    (busy_drv),
      .l_hold      (l_hold),
      .r_hold      (r_hold)
   );

   dpr_port_decode #(.LANES(LANES)) u_dec_l (
      .clk(clk), .rst_n(rst_n), .cs_n(l_cs_n), .rw(l_rw), .oe_n(l_oe_n),
      .be_n(l_be_n), .hold(l_hold), .wr_lane(l_wr), .rd_en(l_rd), .drv_en(l_drv_en)
   );

   dpr_port_decode #(.LANES(LANES)) u_dec_r (
      .clk(clk), .rst_n(rst_n), .cs_n(r_cs_n), .rw(r_rw), .oe_n(r_oe_n),
      .be_n(r_be_n), .hold(r_hold), .wr_lane(r_wr), .rd_en(r_rd), .drv_en(r_drv_en)
   );

   dpr_mem_core #(.ADDR_W(ADDR_W), .LANES(LANES)) u_mem (
      .clk(clk), .rst_n(rst_n),
      .l_addr(l_addr), .l_wdata(l_wdata), .l_wr(l_wr), .l_rd(l_rd), .l_rdata(l_rdata),
      .r_addr(r_addr), .r_wdata(r_wdata), .r_wr(r_wr), .r_rd(r_rd), .r_rdata(r_rdata)
   );
endmodule

// File: rtl/dpr_ctrl_chk.sv
module dpr_ctrl_chk #(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned LANES  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              master_sel,
   input logic              l_cs_n,
   input logic              l_rw,
   input logic              l_oe_n,
   input logic [LANES-1:0]  l_be_n,
   input logic [ADDR_W-1:0] l_addr,
   input logic [LANES-1:0]  l_drv_en,
   input logic              l_busy_out_n,
   input logic              r_cs_n,
   input logic              r_rw,
   input logic              r_oe_n,
   input logic [ADDR_W-1:0] r_addr,
   input logic [LANES-1:0]  r_drv_en,
   input logic              r_busy_out_n,
   input logic              busy_drv
);
   p_desel_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      l_cs_n |=> (l_drv_en == '0));
   p_desel_quiet_right_r1: assert property (@(posedge clk) disable iff (!rst_n)
      r_cs_n |=> (r_drv_en == '0));
   p_lane_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!l_cs_n && l_rw && !l_oe_n) |=> (l_drv_en == ~$past(l_be_n)));
   p_oe_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!r_cs_n && r_rw && r_oe_n) |=> (r_drv_en == '0));
   p_tie_right_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (master_sel && !l_cs_n && !r_cs_n && l_addr == r_addr) |-> (!r_busy_out_n && l_busy_out_n));
   p_left_never_r5: assert property (@(posedge clk) disable iff (!rst_n)
      l_busy_out_n);
   p_slave_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !master_sel |-> (r_busy_out_n && !busy_drv));
   p_drive_role_r9: assert property (@(posedge clk) disable iff (!rst_n)
      master_sel |-> busy_drv);
endmodule

bind dpr_ctrl_top dpr_ctrl_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (.*);

// File: tb/sim_dpr_ctrl_top.sv
module sim_dpr_ctrl_top;
   localparam int AW = 10;
   localparam int LN = 2;
   localparam int DW = 16;

   logic clk = 1'b0, rst_n = 1'b0, master_sel = 1'b1;
   logic l_cs_n = 1, l_rw = 1, l_oe_n = 1, l_busy_in_n = 1;
   logic r_cs_n = 1, r_rw = 1, r_oe_n = 1, r_busy_in_n = 1;
   logic [LN-1:0] l_be_n = '1, r_be_n = '1;
   logic [AW-1:0] l_addr = '0, r_addr = '0;
   logic [DW-1:0] l_wdata = '0, r_wdata = '0;
   logic [DW-1:0] l_rdata, r_rdata;
   logic [LN-1:0] l_drv_en, r_drv_en;
   logic l_busy_out_n, r_busy_out_n, busy_drv;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #4 clk = ~clk;

   dpr_ctrl_top #(.ADDR_W(AW), .LANES(LN)) u0 (.*);

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle();
      l_cs_n = 1; r_cs_n = 1; l_rw = 1; r_rw = 1; l_oe_n = 1; r_oe_n = 1;
      l_be_n = '1; r_be_n = '1;
   endtask

   task automatic l_set(logic rw, logic oe, logic [1:0] be, logic [AW-1:0] a, logic [DW-1:0] d);
      l_cs_n = 0; l_rw = rw; l_oe_n = oe; l_be_n = be; l_addr = a; l_wdata = d;
   endtask

   task automatic r_set(logic rw, logic oe, logic [1:0] be, logic [AW-1:0] a, logic [DW-1:0] d);
      r_cs_n = 0; r_rw = rw; r_oe_n = oe; r_be_n = be; r_addr = a; r_wdata = d;
   endtask

   task automatic l_read_chk(string tag, logic [AW-1:0] a, logic [DW-1:0] exp);
      idle(); l_set(1, 0, 2'b00, a, '0); step(); idle();
      check(tag, 32'(l_rdata), 32'(exp));
   endtask

   task automatic t_reset();
      check("R11 l_rdata", 32'(l_rdata), 0);
      check("R11 l_drv_en", 32'(l_drv_en), 0);
      check("R11 r_rdata", 32'(r_rdata), 0);
      check("R11 r_drv_en", 32'(r_drv_en), 0);
   endtask

   task automatic t_lanes();
      idle(); l_set(0, 1, 2'b00, 5, 16'hA1B2); step();
      l_read_chk("R2 both lanes", 5, 16'hA1B2);
      check("R3 drv both", 32'(l_drv_en), 2'b11);
      idle(); l_set(0, 1, 2'b10, 5, 16'hFFFF); step();
      l_read_chk("R2 lower only", 5, 16'hA1FF);
      idle(); l_set(0, 1, 2'b01, 5, 16'h0000); step();
      l_read_chk("R2 upper only", 5, 16'h00FF);
      idle(); l_set(1, 0, 2'b10, 5, '0); step(); idle();
      check("R3 lower drive", 32'(l_drv_en), 2'b01);
      check("R3 data", 32'(l_rdata), 16'h00FF);
   endtask

   task automatic t_oe();
      idle(); r_set(1, 1, 2'b00, 5, '0); step(); idle();
      check("R4 oe high", 32'(r_drv_en), 0);
   endtask

   task automatic t_desel();
      idle(); l_cs_n = 1; l_rw = 0; l_oe_n = 0; l_be_n = 2'b00; l_addr = 5; l_wdata = 16'h1234;
      step();
      check("R1 drv off", 32'(l_drv_en), 0);
      l_read_chk("R1 no write", 5, 16'h00FF);
   endtask

   task automatic t_master();
      master_sel = 1;
      idle(); l_set(0, 1, 2'b00, 7, 16'h1111); r_set(0, 1, 2'b00, 7, 16'h2222);
      #1;
      check("R5 right flag", 32'(r_busy_out_n), 0);
      check("R5 left flag", 32'(l_busy_out_n), 1);
      check("R9 busy_drv", 32'(busy_drv), 1);
      step();
      l_read_chk("R6 right write dropped", 7, 16'h1111);
      idle(); l_set(0, 1, 2'b00, 8, 16'h8888); r_set(0, 1, 2'b00, 9, 16'h9999);
      #1;
      check("R5 no match", 32'(r_busy_out_n), 1);
      step();
      l_read_chk("R5 left write", 8, 16'h8888);
      l_read_chk("R5 right write", 9, 16'h9999);
   endtask

   task automatic t_both_read();
      idle(); l_set(1, 0, 2'b00, 7, '0); r_set(1, 0, 2'b00, 7, '0);
      #1;
      check("R8 flag on read", 32'(r_busy_out_n), 0);
      step(); idle();
      check("R8 left data", 32'(l_rdata), 16'h1111);
      check("R8 right data", 32'(r_rdata), 16'h1111);
      check("R8 right drive", 32'(r_drv_en), 2'b11);
   endtask

   task automatic t_read_first();
      idle(); l_set(0, 1, 2'b00, 7, 16'h3333); r_set(1, 0, 2'b00, 7, '0);
      step(); idle();
      check("R10 old word", 32'(r_rdata), 16'h1111);
      l_read_chk("R10 new word", 7, 16'h3333);
   endtask

   task automatic t_slave();
      master_sel = 0;
      idle(); l_set(0, 1, 2'b00, 12, 16'h4444); r_set(0, 1, 2'b00, 12, 16'h5555);
      #1;
      check("R7 flags high", 32'({l_busy_out_n, r_busy_out_n}), 2'b11);
      check("R7 busy_drv low", 32'(busy_drv), 0);
      r_busy_in_n = 0;
      step();
      r_busy_in_n = 1;
      l_read_chk("R7 left written", 12, 16'h4444);
      l_busy_in_n = 0;
      idle(); l_set(0, 1, 2'b00, 12, 16'h6666); step();
      l_busy_in_n = 1;
      l_read_chk("R7 held write dropped", 12, 16'h4444);
      idle(); r_set(0, 1, 2'b00, 13, 16'h7777); step();
      idle(); r_set(1, 0, 2'b00, 13, '0); step(); idle();
      check("R7 right free write", 32'(r_rdata), 16'h7777);
      master_sel = 1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_lanes();
      t_oe();
      t_desel();
      t_master();
      t_both_read();
      t_read_first();
      t_slave();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end
endmodule